// File: doc/BRIEF.md
# Clock-Chip Serial Register Initializer

This block brings up an external clock-distribution device after reset by sending it a fixed series of register writes over a three-wire serial link (chip-select, serial clock, serial data out). The writes come from a table computed inside the block. Each write goes out as one 24-bit frame: a 16-bit write instruction that carries the register address, followed by one data byte.

When the last table entry has been sent, the block sends one more write that tells the device to latch its new settings. It then raises `done_o` and keeps it high until the next reset. The rest of the chip can hold its clock consumers in reset until `done_o` is high.

A single step counter times each frame. The `div_i` input sets how many system clocks one step lasts, which in turn sets the serial clock rate.

Top module: `clkcfg_init`

## Requirements
- R1: While `rst_n` is low, `cs_n_o` is 1, `sclk_o` is 1, `sdo_o` is 0 and `done_o` is 0.
- R2: Table entry k, for k from 0 to TABLE_LEN-1, writes register address 0x010 + 3·k with data (37·k + 5) mod 256. The entries are sent in increasing k, starting right after reset.
- R3: Each frame has 24 bits and is sent most significant bit first. The bits are sampled on the 24 rising edges of `sclk_o` while `cs_n_o` is low. Bit 23 is 0 (write), bits 22:21 are 00 (one data byte), bits 20:8 hold the 13-bit address and bits 7:0 hold the data.
- R4: `cs_n_o` is low for the whole of a frame and high at all other times, including before the first frame and after the last one.
- R5: While `cs_n_o` is low, every high and every low phase of `sclk_o` lasts `div_i`+1 system clocks.
- R6: Between the end of one frame and the start of the next, `cs_n_o` stays high for at least two system clocks. The same holds between the release of reset and the first frame.
- R7: The frame after the last table entry writes address 0x05A with data 0x01.
- R8: `done_o` rises only after that update frame has completed, and it then stays high until reset.
- R9: After `done_o` is high, no further frame is sent and `cs_n_o` remains high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | System clocks per step, minus one; hold stable during a run |
| cs_n_o | output | 1 | Serial chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out, frame MSB |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
The assertions check, on every cycle, the following local behaviour:
- A load starts a frame with the chip-select low and the serial clock low.
- The data and clock lines hold still between step ticks.
- A completed frame always returns the shifter to idle.
- A load is never issued while a frame is in flight.
- `done_o` never falls, and no load follows it.

Only the bench scenarios can show the rest, because each of these needs a whole frame or a whole run:
- the bit content and order of every frame,
- the table order and the final update write,
- the phase lengths for each divider value,
- the gap between frames,
- the total frame count.

The bench decodes these from the pins over a sweep of divider settings.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int FRAME_W   = 24;
  localparam int STEP_LAST = 2 * FRAME_W + 1;
  localparam logic [12:0] UPD_ADDR = 13'h05A;
  localparam logic [7:0]  UPD_DATA = 8'h01;

  typedef enum logic [1:0] {
    SQ_GAP    = 2'd0,
    SQ_LAUNCH = 2'd1,
    SQ_BUSY   = 2'd2,
    SQ_DONE   = 2'd3
  } seq_state_e;

  // write instruction: rw=0, count code 00 (one byte), 13-bit address, data byte
  function automatic logic [FRAME_W-1:0] make_write(input logic [12:0] addr,
                                                    input logic [7:0]  data);
    return {1'b0, 2'b00, addr, data};
  endfunction
endpackage

// File: rtl/clkcfg_table.sv
module clkcfg_table
  import clkcfg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0]   idx_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [12:0] addr;
  logic [7:0]  data;
  logic [31:0] idx_ext;

  always_comb begin
    idx_ext = 32'(idx_i);
    if (idx_ext < 32'(ENTRIES)) begin
      addr = 13'(32'h010 + 32'd3 * idx_ext);
      data = 8'(32'd37 * idx_ext + 32'd5);
    end else begin
      addr = UPD_ADDR;
      data = UPD_DATA;
    end
    frame_o = make_write(addr, data);
  end
endmodule

// File: rtl/clkcfg_shifter.sv
module clkcfg_shifter
  import clkcfg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               fin_o,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               sdo_o
);
  localparam int CNT_W = $clog2(STEP_LAST + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(STEP_LAST);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [DIV_W-1:0]   presc_q, presc_d;
  logic               tick;

  always_comb begin
    cnt_d   = cnt_q;
    sreg_d  = sreg_q;
    presc_d = presc_q;
    tick    = (presc_q == div_i);
    if (load_i) begin
      cnt_d   = CNT_W'(1);
      sreg_d  = frame_i;
      presc_d = '0;
    end else if (cnt_q == LAST_C) begin
      cnt_d = '0;
    end else if (cnt_q != '0) begin
      presc_d = tick ? '0 : presc_q + 1'b1;
      if (tick) begin
        cnt_d = cnt_q + 1'b1;
        if (!cnt_q[0]) sreg_d = sreg_q << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sreg_q  <= '0;
      presc_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      sreg_q  <= sreg_d;
      presc_q <= presc_d;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign fin_o  = (cnt_q == LAST_C);
  assign cs_n_o = !busy_o || fin_o;
  assign sclk_o = ~cnt_q[0];
  assign sdo_o  = sreg_q[FRAME_W-1];

  // R4
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!cs_n_o && !sclk_o));
  // R4
  fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> (cs_n_o && !busy_o));
  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fin_o && !tick && !load_i) |=> ($stable(sdo_o) && $stable(sclk_o)));
endmodule

// File: rtl/clkcfg_seq.sv
module clkcfg_seq
  import clkcfg_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int IDX_W    = 4,
  parameter int GAP_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             fin_i,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam int GC_W = $clog2(GAP_CLKS + 1);
  localparam logic [GC_W-1:0]  GAP_END = GC_W'(GAP_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_UPD = IDX_W'(ENTRIES);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [GC_W-1:0]  gap_q, gap_d;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    gap_d  = gap_q;
    load_o = 1'b0;
    case (st_q)
      SQ_GAP: begin
        if (gap_q == GAP_END) begin
          gap_d = '0;
          st_d  = SQ_LAUNCH;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      SQ_LAUNCH: begin
        load_o = 1'b1;
        st_d   = SQ_BUSY;
      end
      SQ_BUSY: begin
        if (fin_i) begin
          if (idx_q == IDX_UPD) begin
            st_d = SQ_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = SQ_GAP;
          end
        end
      end
      default: st_d = SQ_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_GAP;
      idx_q <= '0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      gap_q <= gap_d;
    end
  end

  assign idx_o  = idx_q;
  assign done_o = (st_q == SQ_DONE);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  // R6
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> !busy_i);
  // R9
  no_load_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !load_o);
endmodule

// File: rtl/clkcfg_init.sv
module clkcfg_init
  import clkcfg_pkg::*;
#(
  parameter int TABLE_LEN = 8,
  parameter int DIV_W     = 8,
  parameter int GAP_CLKS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             done_o
);
  localparam int IDX_W = $clog2(TABLE_LEN + 1);

  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] frame;
  logic               load, busy, fin;

  clkcfg_table #(.ENTRIES(TABLE_LEN), .IDX_W(IDX_W)) u_table (
    .idx_i   (idx),
    .frame_o (frame)
  );

  clkcfg_seq #(.ENTRIES(TABLE_LEN), .IDX_W(IDX_W), .GAP_CLKS(GAP_CLKS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (busy),
    .fin_i  (fin),
    .load_o (load),
    .idx_o  (idx),
    .done_o (done_o)
  );

  clkcfg_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_i   (div_i),
    .load_i  (load),
    .frame_i (frame),
    .busy_o  (busy),
    .fin_o   (fin),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .sdo_o   (sdo_o)
  );
endmodule

// File: tb/test_clkcfg_init.sv
module test_clkcfg_init;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div = 8'd0;
  logic       cs_n, sclk, sdo, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit          en = 1'b0;
  logic        p_cs, p_sclk, p_done;
  int          gap, pc, nbits, frames;
  logic [23:0] rx;

  always #2.5 clk = ~clk;

  clkcfg_init #(.TABLE_LEN(N), .DIV_W(8), .GAP_CLKS(2)) i_clkcfg_init (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (div),
    .cs_n_o (cs_n),
    .sclk_o (sclk),
    .sdo_o  (sdo),
    .done_o (done)
  );

  function automatic logic [23:0] exp_frame(input int k);
    if (k < N) return {3'b000, 13'(16 + 3 * k), 8'((37 * k + 5) % 256)};
    return {3'b000, 13'h05A, 8'h01};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (en) begin
      if (cs_n) gap++;
      if (p_cs && !cs_n) begin
        chk(gap >= 2, "R6 gap", gap, 2);
        chk(!done, "R8 done early", int'(done), 0);
        chk(frames <= N, "R9 extra frame", frames, N);
        nbits = 0; rx = '0; gap = 0;
      end
      if (sclk != p_sclk) begin
        if (!p_cs && !cs_n) chk(pc == int'(div) + 1, "R5 phase", pc, int'(div) + 1);
        pc = 1;
      end else begin
        pc++;
      end
      if (!cs_n && sclk && !p_sclk) begin
        rx = {rx[22:0], sdo};
        nbits++;
      end
      if (!p_cs && cs_n) begin
        chk(nbits == 24, "R3 bits", nbits, 24);
        if (frames < N) chk(rx == exp_frame(frames), "R2/R3 frame", int'(rx), int'(exp_frame(frames)));
        else chk(rx == exp_frame(frames), "R7 update", int'(rx), int'(exp_frame(frames)));
        frames++;
      end
      if (done && !p_done) chk(frames == N + 1, "R8 done", frames, N + 1);
      p_cs = cs_n; p_sclk = sclk; p_done = done;
    end
  end

  task automatic run(input int d);
    en = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0;
    div = 8'(d);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n && sclk && !sdo && !done, "R1 reset", int'({cs_n, sclk, sdo, done}), 12);
    p_cs = 1'b1; p_sclk = 1'b1; p_done = 1'b0;
    gap = 0; pc = 1; nbits = 0; frames = 0; rx = '0;
    en = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int t = 0; t < 4000 && !done; t++) @(posedge clk);
    chk(done, "R8 reached", int'(done), 1);
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk(done && cs_n, "R8/R9 hold", int'({done, cs_n}), 3);
    chk(frames == N + 1, "R9 count", frames, N + 1);
    en = 1'b0;
  endtask

  initial begin
    for (int d = 0; d < 5; d++) run(d);
    run(9);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule